// File: doc/BRIEF.md
# Video DAC Pipelined Level Encoder

This block is the digital front end of a three-channel video DAC. On every rising edge of the pixel clock it captures one 8-bit red, green and blue sample together with three video controls: an active-low blank, an active-low sync and an active-high reference white. From the captured values it produces, for each channel, an unsigned level code in DAC LSB units. The code already contains the black setup pedestal and, where enabled, the sync offset, so the analog stage only has to turn the code into a current.

Inside, a pixel-class selector sorts each captured sample into one of three named classes. PC_BLANK covers blank low. PC_WHITE covers blank high with reference white high. PC_ACTIVE covers blank high with reference white low. The class can move from any class to any other on each clock, because the pixel stream sets it. The transitions are ENTER_BLANK (to PC_BLANK), FORCE_WHITE (to PC_WHITE) and SHOW_DATA (to PC_ACTIVE). Sync is handled apart from the class: it only adds or removes an offset on the channels chosen by the `SYNC_MODE` parameter. It never overrides blank, reference white or the colour data.

Top module: `vdac_level_enc`

## Requirements
- R1: All colour bits and all three controls are captured on the same rising clock edge, and the level codes they produce appear exactly one clock later. Before that edge, the outputs still show the previous sample.
- R2: A synchronous reset loads blank low and sync low into the capture register, so all three levels read 0 from the first edge of reset.
- R3: With blank low (0), red and blue read 0 and green reads 111 when sync is high. The colour data and reference white have no effect.
- R4: With blank high (1) and reference white low, red and blue read data+21 and green reads data+21+111 when sync is high.
- R5: With blank high and reference white high (1), each channel uses data code 255 whatever its colour input: red and blue read 276 and green reads 387 when sync is high.
- R6: Sync low (0) removes the 111 offset from green only. It overrides nothing else, so active green with sync low reads data+21.
- R7: With blank low and sync low, all three levels read 0 (sync tip).
- R8: Colour data is straight binary with bit 0 as the least significant bit, so an input of 1 adds exactly 1 LSB to the level.
- R9: Parameter `SYNC_MODE` selects where the sync offset goes: 0 = no channel (green then matches red and blue), 1 = green only (default), 2 = all three channels.
- R10: Each level is 9 bits wide and never exceeds 387, the largest green value, so it never wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock; all inputs are captured on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| red_in | input | 8 | Red sample, straight binary |
| grn_in | input | 8 | Green sample, straight binary |
| blu_in | input | 8 | Blue sample, straight binary |
| blank_n | input | 1 | Blank control, active low |
| sync_n | input | 1 | Sync control, active low |
| ref_white | input | 1 | Reference white force, active high |
| red_lvl | output | 9 | Red level code in LSB units |
| grn_lvl | output | 9 | Green level code in LSB units |
| blu_lvl | output | 9 | Blue level code in LSB units |

## Verification
Every level code is due one rising edge after the sample that produced it, because the capture register is the only storage on the path. The bench therefore drives inputs on the falling edge, waits for the next rising edge, and samples the outputs 1 ns later. In the latency scenario it also samples just before that edge, to confirm the previous sample is still shown. The same stimulus goes to three instances, one for each `SYNC_MODE`, and each output is compared with a level the bench computes from the requirement formulas.

// File: rtl/vdac_pkg.sv
package vdac_pkg;

    // Classification of a captured pixel sample
    typedef enum logic [1:0] {
        PC_BLANK  = 2'd0,
        PC_WHITE  = 2'd1,
        PC_ACTIVE = 2'd2
    } pix_class_e;

    // Captured video controls
    typedef struct packed {
        logic blank_n;
        logic sync_n;
        logic ref_white;
    } vid_ctrl_t;

    localparam int NUM_CH   = 3;
    localparam int CH_GREEN = 1;

    localparam int SYNC_NONE  = 0;
    localparam int SYNC_GREEN = 1;
    localparam int SYNC_ALL   = 2;

endpackage

// File: rtl/vdac_in_reg.sv
module vdac_in_reg
    import vdac_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CH_N   = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [CH_N*DATA_W-1:0]   pix_d,
    input  vid_ctrl_t                ctrl_d,
    output logic [CH_N*DATA_W-1:0]   pix_q,
    output vid_ctrl_t                ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q          <= '0;
            ctrl_q.blank_n <= 1'b0;
            ctrl_q.sync_n  <= 1'b0;
            ctrl_q.ref_white <= 1'b0;
        end else begin
            pix_q  <= pix_d;
            ctrl_q <= ctrl_d;
        end
    end

endmodule

// File: rtl/vdac_class_sel.sv
module vdac_class_sel
    import vdac_pkg::*;
(
    input  vid_ctrl_t  ctrl,
    output pix_class_e cls
);

    // Blank outranks reference white; sync does not take part
    always_comb begin
        unique case ({ctrl.blank_n, ctrl.ref_white})
            2'b00, 2'b01: cls = PC_BLANK;   // ENTER_BLANK
            2'b11:        cls = PC_WHITE;   // FORCE_WHITE
            default:      cls = PC_ACTIVE;  // SHOW_DATA
        endcase
    end

endmodule

// File: rtl/vdac_chan_level.sv
module vdac_chan_level
    import vdac_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int OUT_W    = 9,
    parameter int PEDESTAL = 21,
    parameter int SYNC_OFS = 111,
    parameter bit SYNC_EN  = 1'b0
) (
    input  pix_class_e         cls,
    input  logic               sync_n,
    input  logic [DATA_W-1:0]  data,
    output logic [OUT_W-1:0]   level
);

    localparam logic [OUT_W-1:0] PED_L  = OUT_W'(PEDESTAL);
    localparam logic [OUT_W-1:0] SYNC_L = OUT_W'(SYNC_OFS);

    logic [OUT_W-1:0] base;
    logic [OUT_W-1:0] ped;
    logic [OUT_W-1:0] sync_add;

    always_comb begin
        unique case (cls)
            PC_BLANK: begin
                base = '0;
                ped  = '0;
            end
            PC_WHITE: begin
                base = OUT_W'({DATA_W{1'b1}});
                ped  = PED_L;
            end
            default: begin
                base = OUT_W'(data);
                ped  = PED_L;
            end
        endcase
        sync_add = (SYNC_EN && sync_n) ? SYNC_L : '0;
        level    = base + ped + sync_add;
    end

endmodule

// File: rtl/vdac_level_enc.sv
module vdac_level_enc
    import vdac_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int OUT_W     = 9,
    parameter int PEDESTAL  = 21,
    parameter int SYNC_OFS  = 111,
    parameter int SYNC_MODE = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] red_in,
    input  logic [DATA_W-1:0] grn_in,
    input  logic [DATA_W-1:0] blu_in,
    input  logic              blank_n,
    input  logic              sync_n,
    input  logic              ref_white,
    output logic [OUT_W-1:0]  red_lvl,
    output logic [OUT_W-1:0]  grn_lvl,
    output logic [OUT_W-1:0]  blu_lvl
);

    localparam int PIX_W = NUM_CH * DATA_W;

    logic [PIX_W-1:0]  pix_q;
    vid_ctrl_t         ctrl_d;
    vid_ctrl_t         ctrl_q;
    pix_class_e        cls;
    logic [OUT_W-1:0]  lvl [NUM_CH];

    assign ctrl_d.blank_n   = blank_n;
    assign ctrl_d.sync_n    = sync_n;
    assign ctrl_d.ref_white = ref_white;

    vdac_in_reg #(
        .DATA_W (DATA_W),
        .CH_N   (NUM_CH)
    ) u_in_reg (
        .clk    (clk),
        .rst    (rst),
        .pix_d  ({blu_in, grn_in, red_in}),
        .ctrl_d (ctrl_d),
        .pix_q  (pix_q),
        .ctrl_q (ctrl_q)
    );

    vdac_class_sel u_class (
        .ctrl (ctrl_q),
        .cls  (cls)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        localparam bit CH_SYNC = (SYNC_MODE == SYNC_ALL) ||
                                 ((SYNC_MODE == SYNC_GREEN) && (ch == CH_GREEN));
        vdac_chan_level #(
            .DATA_W   (DATA_W),
            .OUT_W    (OUT_W),
            .PEDESTAL (PEDESTAL),
            .SYNC_OFS (SYNC_OFS),
            .SYNC_EN  (CH_SYNC)
        ) u_lvl (
            .cls    (cls),
            .sync_n (ctrl_q.sync_n),
            .data   (pix_q[ch*DATA_W +: DATA_W]),
            .level  (lvl[ch])
        );
    end

    assign red_lvl = lvl[0];
    assign grn_lvl = lvl[1];
    assign blu_lvl = lvl[2];

endmodule

// File: rtl/vdac_level_enc_chk.sv
module vdac_level_enc_chk #(
    parameter int DATA_W    = 8,
    parameter int OUT_W     = 9,
    parameter int PEDESTAL  = 21,
    parameter int SYNC_OFS  = 111,
    parameter int SYNC_MODE = 1
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] red_in,
    input logic [DATA_W-1:0] grn_in,
    input logic [DATA_W-1:0] blu_in,
    input logic              blank_n,
    input logic              sync_n,
    input logic              ref_white,
    input logic [OUT_W-1:0]  red_lvl,
    input logic [OUT_W-1:0]  grn_lvl,
    input logic [OUT_W-1:0]  blu_lvl
);

    localparam logic [OUT_W-1:0] PED_L  = OUT_W'(PEDESTAL);
    localparam logic [OUT_W-1:0] SYNC_L = OUT_W'(SYNC_OFS);
    localparam logic [OUT_W-1:0] FULL_L = OUT_W'((1 << DATA_W) - 1);
    localparam logic [OUT_W-1:0] MAX_L  = FULL_L + PED_L + SYNC_L;
    localparam bit RB_SYNC = (SYNC_MODE == 2);
    localparam bit G_SYNC  = (SYNC_MODE != 0);

    logic seen_edge;
    always_ff @(posedge clk) seen_edge <= 1'b1;

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
        (seen_edge && $past(rst)) |-> (red_lvl == '0 && grn_lvl == '0 && blu_lvl == '0)); // R2

    AST_BLANK_RB: assert property (@(posedge clk) disable iff (rst)
        (seen_edge && !$past(rst) && !$past(blank_n)) |->
        (red_lvl == ((RB_SYNC && $past(sync_n)) ? SYNC_L : '0) &&
         blu_lvl == ((RB_SYNC && $past(sync_n)) ? SYNC_L : '0))); // R3

    AST_ACTIVE_RED: assert property (@(posedge clk) disable iff (rst)
        (seen_edge && !$past(rst) && $past(blank_n) && !$past(ref_white)) |->
        (red_lvl == OUT_W'($past(red_in)) + PED_L + ((RB_SYNC && $past(sync_n)) ? SYNC_L : '0))); // R4

    AST_WHITE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (seen_edge && !$past(rst) && $past(blank_n) && $past(ref_white)) |->
        (blu_lvl == FULL_L + PED_L + ((RB_SYNC && $past(sync_n)) ? SYNC_L : '0))); // R5

    AST_GREEN_SYNC: assert property (@(posedge clk) disable iff (rst)
        (seen_edge && !$past(rst) && $past(blank_n) && !$past(ref_white)) |->
        (grn_lvl == OUT_W'($past(grn_in)) + PED_L + ((G_SYNC && $past(sync_n)) ? SYNC_L : '0))); // R6

    AST_SYNC_TIP: assert property (@(posedge clk) disable iff (rst)
        (seen_edge && !$past(rst) && !$past(blank_n) && !$past(sync_n)) |->
        (red_lvl == '0 && grn_lvl == '0 && blu_lvl == '0)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        seen_edge |-> (red_lvl <= MAX_L && grn_lvl <= MAX_L && blu_lvl <= MAX_L)); // R10

endmodule

bind vdac_level_enc vdac_level_enc_chk #(
    .DATA_W    (DATA_W),
    .OUT_W     (OUT_W),
    .PEDESTAL  (PEDESTAL),
    .SYNC_OFS  (SYNC_OFS),
    .SYNC_MODE (SYNC_MODE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .red_in    (red_in),
    .grn_in    (grn_in),
    .blu_in    (blu_in),
    .blank_n   (blank_n),
    .sync_n    (sync_n),
    .ref_white (ref_white),
    .red_lvl   (red_lvl),
    .grn_lvl   (grn_lvl),
    .blu_lvl   (blu_lvl)
);

// File: tb/vdac_level_enc_test.sv
`timescale 1ns/1ps
module vdac_level_enc_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] red_in = '0, grn_in = '0, blu_in = '0;
    logic       blank_n = 1'b0, sync_n = 1'b0, ref_white = 1'b0;
    logic [8:0] lv [3][3];   // [mode][channel]

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;    // 250 MHz

    for (genvar m = 0; m < 3; m++) begin : g_dut
        if (m == 1) begin : g_main
            vdac_level_enc #(.SYNC_MODE(1)) uut (
                .clk(clk), .rst(rst), .red_in(red_in), .grn_in(grn_in), .blu_in(blu_in),
                .blank_n(blank_n), .sync_n(sync_n), .ref_white(ref_white),
                .red_lvl(lv[m][0]), .grn_lvl(lv[m][1]), .blu_lvl(lv[m][2]));
        end else begin : g_alt
            vdac_level_enc #(.SYNC_MODE(m)) uut_alt (
                .clk(clk), .rst(rst), .red_in(red_in), .grn_in(grn_in), .blu_in(blu_in),
                .blank_n(blank_n), .sync_n(sync_n), .ref_white(ref_white),
                .red_lvl(lv[m][0]), .grn_lvl(lv[m][1]), .blu_lvl(lv[m][2]));
        end
    end

    function automatic int exp_lvl(int mode, int ch, int d, bit bn, bit sn, bit w);
        int v;
        bit en;
        en = (mode == 2) || (mode == 1 && ch == 1);
        if (!bn)     v = 0;
        else if (w)  v = 255 + 21;
        else         v = d + 21;
        if (en && sn) v = v + 111;
        return v;
    endfunction

    task automatic check(int act, int exp, string req, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(int r, int g, int b, bit bn, bit sn, bit w);
        @(negedge clk);
        red_in = 8'(r); grn_in = 8'(g); blu_in = 8'(b);
        blank_n = bn; sync_n = sn; ref_white = w;
    endtask

    // Drive one sample, wait one edge, compare all modes and channels
    task automatic apply(int r, int g, int b, bit bn, bit sn, bit w, string req, int modes_mask);
        int d[3];
        d[0] = r; d[1] = g; d[2] = b;
        drive(r, g, b, bn, sn, w);
        @(posedge clk); #1;
        for (int m = 0; m < 3; m++) begin
            if (modes_mask[m]) begin
                for (int c = 0; c < 3; c++)
                    check(int'(lv[m][c]), exp_lvl(m, c, d[c], bn, sn, w), req,
                          $sformatf("mode%0d ch%0d", m, c));
            end
        end
    endtask

    task automatic t_reset();   // R2
        rst = 1'b1;
        drive(200, 100, 50, 1'b1, 1'b1, 1'b1);
        @(posedge clk); #1;
        for (int c = 0; c < 3; c++) check(int'(lv[1][c]), 0, "R2", "reset level");
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_active();  // R4, R8
        apply(8'h40, 8'h80, 8'hC3, 1'b1, 1'b1, 1'b0, "R4", 3'b010);
        apply(0, 0, 0, 1'b1, 1'b1, 1'b0, "R4", 3'b010);
        apply(1, 2, 128, 1'b1, 1'b1, 1'b0, "R8", 3'b010);
        apply(8'h55, 8'hAA, 8'h0F, 1'b1, 1'b1, 1'b0, "R8", 3'b010);
    endtask

    task automatic t_white();   // R5
        apply(3, 9, 77, 1'b1, 1'b1, 1'b1, "R5", 3'b010);
        check(int'(lv[1][0]), 276, "R5", "red white");
        check(int'(lv[1][1]), 387, "R5", "green white");
    endtask

    task automatic t_blank();   // R3
        apply(255, 255, 255, 1'b0, 1'b1, 1'b1, "R3", 3'b010);
        check(int'(lv[1][1]), 111, "R3", "green blank");
        apply(90, 33, 12, 1'b0, 1'b1, 1'b0, "R3", 3'b010);
    endtask

    task automatic t_sync();    // R6
        apply(10, 20, 30, 1'b1, 1'b0, 1'b0, "R6", 3'b010);
        check(int'(lv[1][1]), 41, "R6", "green active sync low");
        apply(10, 20, 30, 1'b1, 1'b0, 1'b1, "R6", 3'b010);
    endtask

    task automatic t_tip();     // R7
        apply(255, 128, 7, 1'b0, 1'b0, 1'b1, "R7", 3'b111);
    endtask

    task automatic t_latency(); // R1
        apply(5, 6, 7, 1'b1, 1'b1, 1'b0, "R1", 3'b010);
        drive(100, 101, 102, 1'b1, 1'b1, 1'b0);
        #1;
        check(int'(lv[1][0]), 26, "R1", "red before edge");
        check(int'(lv[1][1]), 138, "R1", "green before edge");
        @(posedge clk); #1;
        check(int'(lv[1][0]), 121, "R1", "red after edge");
        check(int'(lv[1][2]), 123, "R1", "blue after edge");
    endtask

    task automatic t_modes();   // R9
        apply(255, 255, 255, 1'b1, 1'b1, 1'b1, "R9", 3'b111);
        apply(0, 0, 0, 1'b0, 1'b1, 1'b0, "R9", 3'b111);
        apply(64, 64, 64, 1'b1, 1'b1, 1'b0, "R9", 3'b111);
        check(int'(lv[0][1]), int'(lv[0][0]), "R9", "mode0 green equals red");
    endtask

    task automatic t_max();     // R10
        apply(255, 255, 255, 1'b1, 1'b1, 1'b0, "R10", 3'b111);
        check(int'(lv[2][0]), 387, "R10", "mode2 red full scale");
        check(int'(lv[1][1]), 387, "R10", "green full scale");
    endtask

    initial begin
        t_reset();
        t_active();
        t_white();
        t_blank();
        t_sync();
        t_tip();
        t_latency();
        t_modes();
        t_max();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule